// File: doc/BRIEF.md
# Prescaled Timer/Counter

This block is an 8-bit up-counter with two count sources. In timer mode it steps on an internal instruction-cycle tick that fires once every four system clocks. In counter mode it steps on edges of an external pin, after that pin has been brought into the clock domain. An optional power-of-two prescaler sits between the chosen source and the counter. A single option byte selects the source, the edge polarity, whether the prescaler is used, and the prescaler ratio.

Software reaches three locations through a small select-based write/read port: the counter, the option byte and an overflow flag. The flag is set when the counter wraps and stays set until software clears it. A write to the counter restarts the internal divider and the prescaler, then discards the next two count events. This gives software a quiet window after it loads a new value.

Top module: `tcp_timer`

## Requirements
- R1: After reset the counter, the option byte and the overflow flag all read 0.
- R2: Timer mode is selected when option bit 0 = 0. With option bit 2 = 0 the counter rises by one every 4 clocks, and the ratio field in bits 5:3 has no effect.
- R3: When option bit 2 = 1 the prescaler is in use. It passes one count event per 2^(field+1) source events, where the field is option bits 5:3, so ratios run from 2 to 256.
- R4: With option bit 0 = 1 the counter counts edges of `ext_clk_i`, sampled through a two-flop synchroniser. Option bit 1 = 0 selects rising edges; bit 1 = 1 selects falling edges.
- R5: A counter write loads the value, restarts the 4-clock divider and the prescaler, and drops the next two count events. When a write and an increment fall in the same cycle, the written value is kept.
- R6: An increment from FFh yields 00h and sets the overflow flag.
- R7: The overflow flag is sticky. A write to select 2 with data bit 0 = 0 clears it, and a write with bit 0 = 1 leaves it unchanged. If an overflow falls in the same cycle as a clear, the flag ends up set.
- R8: Select codes are: 0 = counter, 1 = option byte (6 bits stored, bits 7:6 read as 0), 2 = overflow flag in bit 0. Select 3 ignores writes and reads as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write target select |
| wr_data_i | input | 8 | Write data |
| rd_sel_i | input | 2 | Read source select |
| rd_data_o | output | 8 | Read data |
| ext_clk_i | input | 1 | External count pin (asynchronous) |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
Two pairs of events can land in the same clock edge. The first is a counter wrap and a software flag clear. The bench loads FEh, waits until the wrapping increment is due, and issues the clear in that exact cycle; the flag must read 1 afterwards. The second is a counter load and a due increment. The bench writes a new value on the cycle a valid tick arrives and expects exactly the written value, not that value plus one.

// File: rtl/tcp_pkg.sv
package tcp_pkg;
  localparam int unsigned RATIO_W = 3;

  typedef enum logic [1:0] {
    SEL_CNT  = 2'd0,
    SEL_OPT  = 2'd1,
    SEL_FLAG = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic [RATIO_W-1:0] ratio;
    logic               to_timer;
    logic               fall_edge;
    logic               ext_src;
  } opt_t;

  localparam int unsigned OPT_W = $bits(opt_t);
endpackage

// File: rtl/tcp_phase_div.sv
module tcp_phase_div #(
  parameter int unsigned DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic tick_o
);
  localparam int unsigned PH_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PH_W-1:0] LAST = PH_W'(DIV - 1);

  logic [PH_W-1:0] ph_q;

  assign tick_o = (ph_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ph_q <= '0;
    else if (clr_i)     ph_q <= '0;
    else if (tick_o)    ph_q <= '0;
    else                ph_q <= ph_q + 1'b1;
  end

  // R2
  tick_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/tcp_edge_sync.sv
module tcp_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= pin_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[STAGES-2:0], pin_i};
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_q <= 1'b0;
    else         last_q <= sync_q[STAGES-1];
  end

  assign rise_o =  sync_q[STAGES-1] & ~last_q;
  assign fall_o = ~sync_q[STAGES-1] &  last_q;

  // R4
  rise_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
  // R4
  fall_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);
endmodule

// File: rtl/tcp_prescale.sv
module tcp_prescale #(
  parameter int unsigned RATIO_W = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               en_i,
  input  logic [RATIO_W-1:0] ratio_i,
  input  logic               src_i,
  output logic               inc_o
);
  localparam int unsigned PRE_W = 1 << RATIO_W;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;
  logic [PRE_W-1:0] ones;

  assign ones  = '1;
  // ratio 2^(field+1): low field+1 bits all ones marks the last source event
  assign mask  = ~(ones << (int'(ratio_i) + 1));
  assign inc_o = src_i & (~en_i | ((pre_q & mask) == mask));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             pre_q <= '0;
    else if (clr_i)          pre_q <= '0;
    else if (src_i && en_i)  pre_q <= pre_q + 1'b1;
  end

  // R3
  inc_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_o |-> src_i);
endmodule

// File: rtl/tcp_timer.sv
module tcp_timer
  import tcp_pkg::*;
#(
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned PHASE_DIV   = 4,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned HOLD_EVENTS = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_sel_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic [1:0]       rd_sel_i,
  output logic [CNT_W-1:0] rd_data_o,
  input  logic             ext_clk_i,
  output logic             ovf_o
);
  localparam int unsigned HOLD_W = $clog2(HOLD_EVENTS + 1);

  opt_t              opt_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              ovf_q;
  logic [HOLD_W-1:0] hold_q;

  logic wr_cnt, wr_opt, wr_flag;
  logic tick, rise, fall, src, inc, take, wrap;

  assign wr_cnt  = wr_en_i & (reg_sel_e'(wr_sel_i) == SEL_CNT);
  assign wr_opt  = wr_en_i & (reg_sel_e'(wr_sel_i) == SEL_OPT);
  assign wr_flag = wr_en_i & (reg_sel_e'(wr_sel_i) == SEL_FLAG);

  tcp_phase_div #(.DIV(PHASE_DIV)) u_phase (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (wr_cnt),
    .tick_o(tick)
  );

  tcp_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pin_i (ext_clk_i),
    .rise_o(rise),
    .fall_o(fall)
  );

  assign src = opt_q.ext_src ? (opt_q.fall_edge ? fall : rise) : tick;

  tcp_prescale #(.RATIO_W(RATIO_W)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (wr_cnt),
    .en_i   (opt_q.to_timer),
    .ratio_i(opt_q.ratio),
    .src_i  (src),
    .inc_o  (inc)
  );

  assign take = inc & (hold_q == '0) & ~wr_cnt;
  assign wrap = take & (cnt_q == '1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     hold_q <= '0;
    else if (wr_cnt)                 hold_q <= HOLD_W'(HOLD_EVENTS);
    else if (inc && hold_q != '0)    hold_q <= hold_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (wr_cnt)  cnt_q <= wr_data_i;
    else if (take)    cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      opt_q <= '0;
    else if (wr_opt)  opt_q <= opt_t'(wr_data_i[OPT_W-1:0]);
  end

  // overflow beats a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       ovf_q <= 1'b0;
    else if (wrap)                     ovf_q <= 1'b1;
    else if (wr_flag && !wr_data_i[0]) ovf_q <= 1'b0;
  end

  always_comb begin
    rd_data_o = '0;
    case (reg_sel_e'(rd_sel_i))
      SEL_CNT:  rd_data_o = cnt_q;
      SEL_OPT:  rd_data_o[OPT_W-1:0] = opt_q;
      SEL_FLAG: rd_data_o[0] = ovf_q;
      default:  rd_data_o = '0;
    endcase
  end

  assign ovf_o = ovf_q;

  // R5
  load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cnt |=> cnt_q == $past(wr_data_i));
  // R5
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_q != '0 && !wr_cnt) |=> cnt_q == $past(cnt_q));
  // R2
  step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_cnt |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1));
  // R6
  wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '1 && !wr_cnt) |=> (cnt_q == '1 || (cnt_q == '0 && ovf_q)));
  // R7
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q && !(wr_flag && !wr_data_i[0])) |=> ovf_q);
endmodule

// File: tb/tcp_timer_bench.sv
module tcp_timer_bench;
  typedef struct packed {
    logic [7:0]  opt;
    logic [7:0]  wval;
    logic [15:0] amt;
    logic [7:0]  exp;
  } vec_t;

  // timer: amt = clocks after load; counter: amt = full pulses (plus one final rise)
  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{8'h00, 8'h10, 16'd40,   8'h18},
    '{8'h04, 8'h20, 16'd80,   8'h28},
    '{8'h0C, 8'h00, 16'd160,  8'h08},
    '{8'h3C, 8'h05, 16'd5120, 8'h08},
    '{8'h38, 8'h30, 16'd40,   8'h38},
    '{8'h00, 8'h77, 16'd11,   8'h77},
    '{8'h00, 8'h77, 16'd12,   8'h78},
    '{8'h01, 8'h40, 16'd5,    8'h44},
    '{8'h03, 8'h40, 16'd5,    8'h43},
    '{8'h05, 8'h00, 16'd9,    8'h03}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic [1:0] rd_sel = 2'd0;
  logic [7:0] rd_data;
  logic       ext = 1'b0;
  logic       ovf;
  int         checks = 0;
  int         fails = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  tcp_timer u_tcp_timer (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .rd_sel_i(rd_sel), .rd_data_o(rd_data),
    .ext_clk_i(ext), .ovf_o(ovf)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  // ends at the falling edge after the write edge
  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1
    rd_sel = 2'd0; #1 check("R1 count", rd_data, 8'h00);
    rd_sel = 2'd1; #1 check("R1 option", rd_data, 8'h00);
    check("R1 flag", {7'd0, ovf}, 8'h00);
    rd_sel = 2'd0;

    for (int v = 0; v < NV; v++) begin
      string tag;
      tag = VECS[v].opt[0] ? "R4" : (VECS[v].opt[2] ? "R3" : "R2");
      wr(2'd1, VECS[v].opt);
      if (VECS[v].opt[0]) begin
        ext = 1'b0;
        repeat (8) @(negedge clk);
        wr(2'd0, VECS[v].wval);
        for (int p = 0; p < VECS[v].amt; p++) begin
          ext = 1'b1; repeat (4) @(negedge clk);
          ext = 1'b0; repeat (4) @(negedge clk);
        end
        ext = 1'b1;
        repeat (8) @(negedge clk);
      end else begin
        wr(2'd0, VECS[v].wval);
        repeat (VECS[v].amt) @(posedge clk);
        @(negedge clk);
      end
      check(tag, rd_data, VECS[v].exp);
    end
    ext = 1'b0;
    repeat (8) @(negedge clk);

    // R6 wrap, timer mode no prescaler
    wr(2'd1, 8'h00);
    wr(2'd0, 8'hFE);
    repeat (15) @(posedge clk);
    @(negedge clk);
    check("R6 before wrap", rd_data, 8'hFF);
    check("R6 flag before wrap", {7'd0, ovf}, 8'h00);
    @(posedge clk); @(negedge clk);
    check("R6 wrapped", rd_data, 8'h00);
    check("R6 flag set", {7'd0, ovf}, 8'h01);

    // R7 sticky / clear / write-one ignored
    repeat (20) @(negedge clk);
    check("R7 sticky", {7'd0, ovf}, 8'h01);
    wr(2'd2, 8'h00);
    check("R7 cleared", {7'd0, ovf}, 8'h00);
    wr(2'd2, 8'h01);
    rd_sel = 2'd2; #1 check("R7 write one", rd_data, 8'h00);
    rd_sel = 2'd0;

    // R7 collision: overflow and clear on the same edge
    wr(2'd0, 8'hFE);
    repeat (15) @(posedge clk);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 2'd2; wr_data = 8'h00;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
    check("R7 overflow beats clear", {7'd0, ovf}, 8'h01);
    wr(2'd2, 8'h00);

    // R5 load on the cycle an increment is due
    wr(2'd0, 8'h50);
    repeat (11) @(posedge clk);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 2'd0; wr_data = 8'h90;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
    check("R5 write wins", rd_data, 8'h90);
    repeat (8) @(posedge clk); @(negedge clk);
    check("R5 two events dropped", rd_data, 8'h90);

    // R8 map
    wr(2'd1, 8'hFF);
    rd_sel = 2'd1; #1 check("R8 option width", rd_data, 8'h3F);
    wr(2'd1, 8'h3D);
    wr(2'd0, 8'hA0);
    wr(2'd3, 8'h11);
    rd_sel = 2'd0; #1 check("R8 sel3 write ignored", rd_data, 8'hA0);
    rd_sel = 2'd3; #1 check("R8 sel3 reads zero", rd_data, 8'h00);
    rd_sel = 2'd0;

    finish_run();
  end
endmodule